// File: doc/BRIEF.md
# Tamper Detection Channel

This block is a single tamper-sensing channel for an always-on, battery-backed domain. It runs from a 32768 Hz clock and watches a pair of tamper pins. In passive mode it compares each pin against a level that software programmed. In active mode it runs a Galois linear feedback shift register (LFSR) with a programmable polynomial. The low bit of the LFSR goes out on a drive pin, and the channel expects to see the same bit come back on the return pin. Any disagreement can pass through a glitch filter with a programmable length, or it can skip the filter. The result is reported as one violation line per pin.

Software sets the channel up through a small register write port with three registers. A control word holds the mode, rate, filter, recovery and lock settings. The polynomial register can be written only once. The seed register can be written but not read back. Once the lock bit is set, the control word cannot change until the domain reset. Latching the flags and raising interrupts belong to the surrounding logic.

Top module: `tamper_channel`

## Requirements
- R1: After the asynchronous reset both violation bits are 0, `pinOut` is 0, and all three registers read 0.
- R2: While control bit 0 (enable) is 0, both violation bits stay 0 and `pinOut` stays 0, whatever the pins do.
- R3: In passive mode (enable 1, control bit 1 = 0), pin i counts as mismatched when `pinIn[i]` differs from control bit 8+i (the expected level). A mismatch on pin i is reported on `violation[i]`.
- R4: With the filter in use, a mismatch is reported only after it has been present at 2^F consecutive clock edges, where F is control bits 19:16. It is reported after the 2^F-th edge. A mismatch that lasts fewer edges is never reported.
- R5: When control bit 20 is 1, the filter is skipped and the raw mismatch appears on the violation output in the same cycle.
- R6: In active mode (control bit 1 = 1), the LFSR advances once every 2^(CLK_LOG2 − min(S, CLK_LOG2)) clocks, where S is control bits 7:4. Each step computes next = (s >> 1) XOR (s[0] ? poly : 0), and `pinOut` carries s[0].
- R7: In active mode, at every shift instant `pinIn[1]` is compared with the bit being driven at that moment. A mismatch sets `violation[1]`. While control bit 2 (recover) is 0, the violation then holds for as long as the channel stays enabled.
- R8: When recover is 1, a mismatch at a shift instant reloads the LFSR from the stored seed instead of advancing it. The violation clears at the next shift instant whose returned bit matches.
- R9: The first write to register 1 (polynomial) is kept and every later write is ignored. The register reads 1 once it has been written, and 0 before that.
- R10: A write to register 2 (seed) stores the seed and loads the LFSR straight away. Reads of register 2 always return 0.
- R11: Once control bit 31 (lock) is 1, writes to register 0 have no effect on the stored settings or on behaviour until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz domain clock |
| rstN | input | 1 | Asynchronous active-low domain reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write target: 0 control, 1 polynomial, 2 seed |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read select, same encoding as wrAddr |
| rdData | output | 32 | Combinational read data |
| pinIn | input | 2 | Sensed tamper pin levels; bit 1 is the active return pin |
| pinOut | output | 1 | Active-mode drive bit |
| violation | output | 2 | Per-pin violation indication |

## Verification
The bench builds the channel with CLK_LOG2 = 4 and the full 32-bit LFSR. With that setting the slowest rate (S = 0) steps every 16 clocks, and every S of 4 or above steps on every clock. This brings the saturation of the rate field, a mid-range rate and the slowest rate within a few hundred cycles. The pins are looped back with an optional inversion, so a correct loop, a broken loop and a loop that is broken once and then repaired can all be applied in the middle of a sequence. Filter lengths of 1 and 4 edges are used to show both the reporting threshold and rejection of a glitch one edge shorter.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

  localparam int REG_W = 32;

  // control word bit positions
  localparam int B_EN   = 0;
  localparam int B_ACT  = 1;
  localparam int B_REC  = 2;
  localparam int SPD_LO = 4;
  localparam int VAL_LO = 8;
  localparam int FLT_LO = 16;
  localparam int B_BYP  = 20;
  localparam int B_LOCK = 31;
  localparam logic [REG_W-1:0] CTRL_MASK = 32'h801F_03F7;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_POLY = 2'd1,
    SEL_SEED = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic       enable;
    logic       active;
    logic       recover;
    logic       bypass;
    logic [3:0] filterLen;
    logic [1:0] expectLvl;
    logic       tick;
    logic       seedLoad;
  } strobe_t;

endpackage

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
  import tamper_pkg::*;
#(
  parameter int LFSR_W   = 32,
  parameter int CLK_LOG2 = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [1:0]        rdAddr,
  output logic [REG_W-1:0]  rdData,
  output strobe_t           st,
  output logic [LFSR_W-1:0] polyVal,
  output logic [LFSR_W-1:0] seedVal
);

  localparam int DIV_W = CLK_LOG2 + 1;

  logic [REG_W-1:0]  ctrlReg;
  logic [LFSR_W-1:0] polyReg;
  logic [LFSR_W-1:0] seedReg;
  logic              polyWritten;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  periodM1;
  logic [4:0]        effSpeed;
  logic              running;
  logic              locked;
  logic              wrCtrl, wrPoly, wrSeed;
  logic              tick;

  assign locked = ctrlReg[B_LOCK];
  assign wrCtrl = wrEn && (regSel_e'(wrAddr) == SEL_CTRL);
  assign wrPoly = wrEn && (regSel_e'(wrAddr) == SEL_POLY);
  assign wrSeed = wrEn && (regSel_e'(wrAddr) == SEL_SEED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl && !locked) begin
      ctrlReg <= wrData & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polyReg     <= '0;
      polyWritten <= 1'b0;
    end else if (wrPoly && !polyWritten) begin
      polyReg     <= wrData[LFSR_W-1:0];
      polyWritten <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedReg <= '0;
    end else if (wrSeed) begin
      seedReg <= wrData[LFSR_W-1:0];
    end
  end

  // shift-rate divider
  assign running = ctrlReg[B_EN] && ctrlReg[B_ACT];

  always_comb begin
    if ({1'b0, ctrlReg[SPD_LO +: 4]} > 5'(CLK_LOG2)) effSpeed = 5'(CLK_LOG2);
    else effSpeed = {1'b0, ctrlReg[SPD_LO +: 4]};
    periodM1 = (DIV_W'(1) << (5'(CLK_LOG2) - effSpeed)) - DIV_W'(1);
  end

  assign tick = running && (divCnt >= periodM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!running || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    st.enable    = ctrlReg[B_EN];
    st.active    = ctrlReg[B_ACT];
    st.recover   = ctrlReg[B_REC];
    st.bypass    = ctrlReg[B_BYP];
    st.filterLen = ctrlReg[FLT_LO +: 4];
    st.expectLvl = ctrlReg[VAL_LO +: 2];
    st.tick      = tick;
    st.seedLoad  = wrSeed;
  end

  assign polyVal = polyReg;
  assign seedVal = wrSeed ? wrData[LFSR_W-1:0] : seedReg;

  always_comb begin
    case (regSel_e'(rdAddr))
      SEL_CTRL: rdData = ctrlReg;
      SEL_POLY: rdData = {{(REG_W-1){1'b0}}, polyWritten};
      default:  rdData = '0;
    endcase
  end

  // R9
  poly_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (polyWritten && wrPoly) |=> $stable(polyReg));

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[B_LOCK] |=> $stable(ctrlReg));

  // R6
  divider_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (divCnt == '0));

endmodule

// File: rtl/tamper_datapath.sv
module tamper_datapath
  import tamper_pkg::*;
#(
  parameter int LFSR_W = 32,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [LFSR_W-1:0] polyVal,
  input  logic [LFSR_W-1:0] seedVal,
  input  logic [1:0]        pinIn,
  output logic              pinOut,
  output logic [1:0]        violation
);

  localparam int CNT_W = 2 ** FILT_W;

  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrNext;
  logic              activeOn;
  logic              mismatch;
  logic              activeErr;
  logic [1:0]        raw;
  logic [1:0]        filtVec;

  assign activeOn = st.enable && st.active;
  assign mismatch = pinIn[1] != lfsr[0];
  assign lfsrNext = (lfsr >> 1) ^ (lfsr[0] ? polyVal : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= '0;
    end else if (st.seedLoad) begin
      lfsr <= seedVal;
    end else if (activeOn && st.tick) begin
      if (mismatch && st.recover) lfsr <= seedVal;
      else lfsr <= lfsrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeErr <= 1'b0;
    end else if (!activeOn) begin
      activeErr <= 1'b0;
    end else if (st.tick) begin
      if (mismatch) activeErr <= 1'b1;
      else if (st.recover) activeErr <= 1'b0;
    end
  end

  assign pinOut = activeOn && lfsr[0];

  always_comb begin
    raw[0] = st.enable && !st.active && (pinIn[0] != st.expectLvl[0]);
    raw[1] = st.enable && (st.active ? activeErr : (pinIn[1] != st.expectLvl[1]));
  end

  for (genvar i = 0; i < 2; i++) begin : g_filt
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cntInc;
    logic             filtQ;

    assign cntInc = (&cnt) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt   <= '0;
        filtQ <= 1'b0;
      end else if (!st.enable || !raw[i]) begin
        cnt   <= '0;
        filtQ <= 1'b0;
      end else begin
        cnt   <= cntInc;
        filtQ <= cntInc >= (CNT_W'(1) << st.filterLen);
      end
    end

    assign filtVec[i] = filtQ;

    // R4
    filter_age_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(filtQ) |-> $past(raw[i]));
  end

  assign violation = st.enable ? (st.bypass ? raw : filtVec) : 2'b00;

  // R2
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.enable |=> !activeErr);

  // R6
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tick && !st.seedLoad) |=> $stable(lfsr));

  // R7
  active_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeErr && activeOn && !st.recover) |=> activeErr);

endmodule

// File: rtl/tamper_channel.sv
module tamper_channel
  import tamper_pkg::*;
#(
  parameter int LFSR_W   = 32,
  parameter int CLK_LOG2 = 15,
  parameter int FILT_W   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  input  logic [1:0]  pinIn,
  output logic        pinOut,
  output logic [1:0]  violation
);

  strobe_t           st;
  logic [LFSR_W-1:0] polyVal;
  logic [LFSR_W-1:0] seedVal;

  tamper_ctrl #(
    .LFSR_W  (LFSR_W),
    .CLK_LOG2(CLK_LOG2)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .st     (st),
    .polyVal(polyVal),
    .seedVal(seedVal)
  );

  tamper_datapath #(
    .LFSR_W(LFSR_W),
    .FILT_W(FILT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .polyVal  (polyVal),
    .seedVal  (seedVal),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .violation(violation)
  );

endmodule

// File: tb/tamper_channel_test.sv
module tamper_channel_test;

  localparam logic [31:0] POLY_A = 32'h8020_0003;
  localparam logic [31:0] POLY_B = 32'h0000_0000;
  localparam logic [31:0] SEED   = 32'hA5A5_5A5B;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic [1:0]  rdAddr = 2'd0;
  logic [31:0] rdData;
  logic        pinOut;
  logic [1:0]  violation;
  logic        p0 = 1'b0, p1 = 1'b0, loopBack = 1'b0, loopInv = 1'b0;
  logic [1:0]  pinIn;
  int          checks = 0, errors = 0;

  assign pinIn = {loopBack ? (pinOut ^ loopInv) : p1, p0};

  tamper_channel #(.CLK_LOG2(4)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .violation(violation)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] step(input logic [31:0] s, input logic [31:0] p);
    return s[0] ? ((s >> 1) ^ p) : (s >> 1);
  endfunction

  function automatic logic [31:0] ctl(input bit en, input bit act, input bit rec,
      input int spd, input logic [1:0] val, input int flt, input bit byp, input bit lck);
    logic [31:0] c = '0;
    c[0] = en; c[1] = act; c[2] = rec; c[7:4] = 4'(spd); c[9:8] = val;
    c[19:16] = 4'(flt); c[20] = byp; c[31] = lck;
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    check("R1 violation after reset", 32'(violation), 0);
    check("R1 pinOut after reset", 32'(pinOut), 0);
    rd(2'd0, 0, "R1 control read");
    rd(2'd1, 0, "R1 poly read");
    rd(2'd2, 0, "R1 seed read");
  endtask

  task automatic t_regs();
    wr(2'd1, POLY_A);
    rd(2'd1, 1, "R9 poly reads one");
    wr(2'd1, POLY_B);
    rd(2'd1, 1, "R9 poly still one");
    wr(2'd2, SEED);
    rd(2'd2, 0, "R10 seed reads zero");
  endtask

  task automatic t_disabled();
    p0 = 1'b1; p1 = 1'b1;
    wr(2'd0, ctl(0, 0, 0, 0, 2'b00, 0, 1, 0));
    repeat (3) @(negedge clk);
    check("R2 disabled violation", 32'(violation), 0);
    check("R2 disabled pinOut", 32'(pinOut), 0);
  endtask

  task automatic t_passive_bypass();
    p0 = 1'b0; p1 = 1'b1;
    wr(2'd0, ctl(1, 0, 0, 0, 2'b10, 3, 1, 0));
    check("R3 levels match", 32'(violation), 0);
    p0 = 1'b1; #1;
    check("R5 bypass immediate pin0", 32'(violation), 32'b01);
    p1 = 1'b0; #1;
    check("R3 both pins mismatched", 32'(violation), 32'b11);
    p0 = 1'b0; p1 = 1'b1; #1;
    check("R3 restored", 32'(violation), 0);
  endtask

  task automatic t_filter();
    p0 = 1'b0; p1 = 1'b0;
    wr(2'd0, ctl(1, 0, 0, 0, 2'b00, 2, 0, 0));
    p0 = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check("R4 below filter length", 32'(violation), 0);
    end
    @(negedge clk);
    check("R4 reported after four edges", 32'(violation), 32'b01);
    p0 = 1'b0;
    @(negedge clk);
    check("R4 cleared after mismatch ends", 32'(violation), 0);
    p0 = 1'b1;
    repeat (3) @(negedge clk);
    p0 = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R4 glitch rejected", 32'(violation), 0);
    end
    wr(2'd0, ctl(1, 0, 0, 0, 2'b00, 0, 0, 0));
    p1 = 1'b1;
    #1;
    check("R4 single-edge filter not yet", 32'(violation), 0);
    @(negedge clk);
    check("R4 single-edge filter reported", 32'(violation), 32'b10);
    p1 = 1'b0;
  endtask

  task automatic t_rate(input int spd, input int period);
    logic [31:0] model;
    wr(2'd0, 0);
    wr(2'd2, SEED);
    loopBack = 1'b1; loopInv = 1'b0;
    wr(2'd0, ctl(1, 1, 0, spd, 2'b00, 0, 1, 0));
    model = SEED;
    check("R6 first driven bit", 32'(pinOut), 32'(model[0]));
    for (int k = 1; k <= 4 * period + 2; k++) begin
      @(negedge clk);
      if (k % period == 0) model = step(model, POLY_A);
      check("R6 drive sequence and rate", 32'(pinOut), 32'(model[0]));
    end
    check("R7 good loop no violation", 32'(violation), 0);
  endtask

  task automatic t_active_fail();
    wr(2'd0, 0);
    wr(2'd2, SEED);
    loopBack = 1'b1; loopInv = 1'b1;
    wr(2'd0, ctl(1, 1, 0, 15, 2'b00, 0, 1, 0));
    @(negedge clk);
    check("R7 broken loop flagged", 32'(violation), 32'b10);
    loopInv = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 violation sticky without recover", 32'(violation), 32'b10);
    wr(2'd0, 0);
    check("R2 disable clears active violation", 32'(violation), 0);
  endtask

  task automatic t_recover();
    logic [31:0] model;
    wr(2'd0, 0);
    wr(2'd2, SEED);
    loopBack = 1'b1; loopInv = 1'b0;
    wr(2'd0, ctl(1, 1, 1, 2, 2'b00, 0, 1, 0));
    model = SEED;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k % 4 == 0) model = step(model, POLY_A);
    end
    check("R6 state before fault", 32'(pinOut), 32'(model[0]));
    loopInv = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 fault flagged", 32'(violation), 32'b10);
    check("R8 LFSR reloaded from seed", 32'(pinOut), 32'(SEED[0]));
    loopInv = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 held until next shift", 32'(violation), 32'b10);
    @(negedge clk);
    check("R8 violation cleared on match", 32'(violation), 0);
    check("R8 sequence resumes from seed", 32'(pinOut), 32'(step(SEED, POLY_A) & 32'd1));
    loopBack = 1'b0;
    wr(2'd0, 0);
  endtask

  task automatic t_lock();
    logic [31:0] lockedVal;
    p0 = 1'b0; p1 = 1'b0;
    lockedVal = ctl(1, 0, 0, 0, 2'b00, 0, 1, 1);
    wr(2'd0, lockedVal);
    wr(2'd0, 0);
    rd(2'd0, lockedVal, "R11 control unchanged");
    p0 = 1'b1; #1;
    check("R11 channel still enabled", 32'(violation), 32'b01);
    p0 = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd0, 0, "R1 reset releases lock");
    rd(2'd1, 0, "R1 poly unwritten after reset");
    check("R1 violation after second reset", 32'(violation), 0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_passive_bypass();
    t_filter();
    t_rate(15, 1);
    t_rate(2, 4);
    t_rate(0, 16);
    t_active_fail();
    t_recover();
    t_lock();
    finish_run();
  end

endmodule